// File: doc/BRIEF.md
# Bi-phase Infrared Transmitter

This block turns a remote-control request into the on/off envelope of a bi-phase (Manchester) coded infrared frame. It takes a 5-bit device address and a 7-bit command and builds the payload itself, including a toggle flag that alternates from one request to the next. It then sends one start symbol followed by thirteen payload symbols. A separate modulator gates the carrier with the envelope; this block does not generate the carrier.

All frame timing comes from a single-cycle `tick_en` strobe, which is typically a 10 kHz enable derived from the system clock. Each symbol is two equal half-bit slots of `HALF_TICKS` ticks. There is no separate timing for the start symbol or for the end of the frame. `busy` covers the whole frame. A request that arrives while `busy` is high is dropped.

Top module: `irtx_biphase_tx`

## Requirements
- R1: While reset is asserted, and for the cycles after reset is released until the first request, `busy` and `ir_env` are both 0.
- R2: A `send_req` sampled high while `busy` is 0 raises `busy` at that clock edge. The frame lasts 14 symbols of 2×`HALF_TICKS` ticks each. `busy` stays 1 until the tick that ends the last half-bit.
- R3: Frame state advances only on cycles where `tick_en` is 1. With `tick_en` held at 0, `ir_env` and `busy` do not change.
- R4: A payload 1 is sent as a dark half-bit (`ir_env`=0) followed by a lit half-bit (`ir_env`=1). A payload 0 is sent as lit then dark.
- R5: The start symbol always uses the pattern of a 1, so every frame begins with a dark half-bit.
- R6: After the start symbol, the symbols are sent in this order: inverted `cmd[6]`, the toggle flag, `addr[4]` down to `addr[0]`, then `cmd[5]` down to `cmd[0]`.
- R7: The toggle flag is 0 after reset and inverts on every accepted request, so the first frame after reset carries 1.
- R8: A `send_req` while `busy` is 1 is ignored. The running frame continues unchanged, and the toggle flag does not invert.
- R9: When the last half-bit ends, `busy` returns to 0 and `ir_env` is forced to 0. The block then accepts the next request.
- R10: `addr` and `cmd` are captured when a request is accepted. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Single-cycle timing enable; one pulse per tick |
| send_req | input | 1 | Request to send a frame; accepted only while idle |
| addr | input | 5 | Device address for the frame |
| cmd | input | 7 | Command; bit 6 is sent inverted |
| ir_env | output | 1 | Carrier envelope: 1 means carrier on |
| busy | output | 1 | High while a frame is in progress |

## Verification
The assertions assume three things about the inputs:
- `tick_en` is a clean single-cycle pulse.
- Requests arrive as ordinary synchronous levels.
- The envelope may move only on a cycle after a tick or an accepted request.

The directed stimulus keeps ticks apart by at least two idle clocks. It raises `send_req` only on cycles with no tick. It also inserts deliberate gaps without ticks, late requests, and mid-frame changes to address and command. These show that the envelope holds its value and the frame content was captured at acceptance.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int unsigned ADDR_W       = 5;
  localparam int unsigned CMD_W        = 7;
  localparam int unsigned PAYLOAD_BITS = 2 + ADDR_W + (CMD_W - 1);
  localparam int unsigned SYMBOLS      = PAYLOAD_BITS + 1;
  localparam int unsigned SYM_W        = $clog2(SYMBOLS);

  // Frame image, sent MSB first: start symbol, inverted cmd[6], toggle,
  // address, then the six low command bits.
  function automatic logic [SYMBOLS-1:0] pack_frame(
    input logic [ADDR_W-1:0] a,
    input logic [CMD_W-1:0]  c,
    input logic              tog
  );
    return {1'b1, ~c[CMD_W-1], tog, a, c[CMD_W-2:0]};
  endfunction
endpackage

// File: rtl/irtx_rst_sync.sv
module irtx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/irtx_half_timer.sv
module irtx_half_timer #(
  parameter int unsigned HALF_TICKS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  input  logic restart,
  output logic half_end
);
  localparam int unsigned CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             adv;

  assign adv      = run & tick_en;
  assign half_end = adv & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)       cnt_d = '0;
    else if (half_end) cnt_d = '0;
    else if (adv)      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irtx_sequencer.sv
module irtx_sequencer
  import irtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic half_end,
  output logic busy,
  output logic second_half,
  output logic sym_end
);
  logic             busy_q, busy_d;
  logic             half_q, half_d;
  logic [SYM_W-1:0] idx_q, idx_d;
  logic             last_sym;

  assign sym_end  = half_end & half_q;
  assign last_sym = (idx_q == SYM_W'(SYMBOLS - 1));

  always_comb begin
    busy_d = busy_q;
    half_d = half_q;
    idx_d  = idx_q;
    if (start) begin
      busy_d = 1'b1;
      half_d = 1'b0;
      idx_d  = '0;
    end else if (half_end) begin
      half_d = ~half_q;
      if (half_q) begin
        if (last_sym) begin
          busy_d = 1'b0;
          idx_d  = '0;
        end else begin
          idx_d = idx_q + SYM_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      half_q <= half_d;
      idx_q  <= idx_d;
    end
  end

  assign busy        = busy_q;
  assign second_half = half_q;
endmodule

// File: rtl/irtx_payload.sv
module irtx_payload
  import irtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  cmd,
  output logic              cur_bit
);
  logic [SYMBOLS-1:0] sr_q, sr_d;
  logic               tog_q, tog_d;

  always_comb begin
    sr_d  = sr_q;
    tog_d = tog_q;
    if (load) begin
      tog_d = ~tog_q;
      sr_d  = pack_frame(addr, cmd, ~tog_q);
    end else if (shift) begin
      sr_d = {sr_q[SYMBOLS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      tog_q <= tog_d;
    end
  end

  assign cur_bit = sr_q[SYMBOLS-1];
endmodule

// File: rtl/irtx_biphase_tx.sv
module irtx_biphase_tx
  import irtx_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              send_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  cmd,
  output logic              ir_env,
  output logic              busy
);
  logic rst_sync_n;
  logic accept;
  logic half_end;
  logic sym_end;
  logic second_half;
  logic cur_bit;
  logic busy_w;

  irtx_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign accept = send_req & ~busy_w;

  irtx_half_timer #(.HALF_TICKS(HALF_TICKS)) timer_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (busy_w),
    .tick_en  (tick_en),
    .restart  (accept),
    .half_end (half_end)
  );

  irtx_sequencer seq_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (accept),
    .half_end    (half_end),
    .busy        (busy_w),
    .second_half (second_half),
    .sym_end     (sym_end)
  );

  irtx_payload payload_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (accept),
    .shift   (sym_end),
    .addr    (addr),
    .cmd     (cmd),
    .cur_bit (cur_bit)
  );

  // A one is dark then lit; a zero is lit then dark.
  assign ir_env = busy_w & ~(cur_bit ^ second_half);
  assign busy   = busy_w;
endmodule

// File: rtl/irtx_biphase_tx_chk.sv
module irtx_biphase_tx_chk (
  input logic clk,
  input logic srst_n,
  input logic tick_en,
  input logic send_req,
  input logic busy,
  input logic ir_env
);
  p_idle_dark_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !busy |-> !ir_env);

  p_env_tick_only_r3: assert property (@(posedge clk) disable iff (!srst_n)
    !tick_en |=> $stable(ir_env));

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!srst_n)
    busy && !tick_en |=> busy);

  p_busy_ends_on_tick_r2: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(busy) |-> $past(tick_en));

  p_accept_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !busy && send_req |=> busy);

  p_start_dark_r5: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy) |-> !ir_env);

  p_req_ignored_r8: assert property (@(posedge clk) disable iff (!srst_n)
    busy && send_req && !tick_en |=> busy && $stable(ir_env));
endmodule

bind irtx_biphase_tx irtx_biphase_tx_chk chk_i (
  .clk      (clk),
  .srst_n   (rst_sync_n),
  .tick_en  (tick_en),
  .send_req (send_req),
  .busy     (busy),
  .ir_env   (ir_env)
);

// File: tb/irtx_biphase_tx_tb_top.sv
module irtx_biphase_tx_tb_top;
  localparam int unsigned HALF = 9;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       send_req;
  logic [4:0] addr;
  logic [6:0] cmd;
  logic       ir_env;
  logic       busy;

  int   n_vec = 0;
  int   n_bad = 0;
  logic tog_model;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  irtx_biphase_tx #(.HALF_TICKS(HALF)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .send_req (send_req),
    .addr     (addr),
    .cmd      (cmd),
    .ir_env   (ir_env),
    .busy     (busy)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic tick_once();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick_en = 1'b0; send_req = 1'b0;
    addr = '0; cmd = '0; tog_model = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", busy, 1'b0, "busy in reset");
    chk("R1", ir_env, 1'b0, "env in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", busy, 1'b0, "busy after release");
    chk("R1", ir_env, 1'b0, "env after release");
    repeat (3) tick_once();
    chk("R1", ir_env, 1'b0, "env with idle ticks");
  endtask

  // mode 0: plain, 1: late request plus input change, 2: long tick gap
  task automatic t_frame(input logic [4:0] a, input logic [6:0] c, input int mode);
    logic [13:0] bits;
    logic        b, e;
    string       tag;
    chk("R9", busy, 1'b0, "idle before request");
    tog_model = ~tog_model;
    bits = {1'b1, ~c[6], tog_model, a, c[5:0]};
    addr = a; cmd = c; send_req = 1'b1;
    @(negedge clk);
    send_req = 1'b0;
    chk("R2", busy, 1'b1, "busy after accept");
    for (int k = 0; k < 28; k++) begin
      for (int j = 0; j < int'(HALF); j++) begin
        b = bits[13 - k/2];
        e = (k % 2 == 1) ? b : ~b;
        if (k / 2 == 0)                tag = "R5";
        else if (k / 2 == 2)           tag = "R7";
        else if (mode == 1 && k >= 19) tag = "R10";
        else if (j == 0)               tag = "R6";
        else                           tag = "R4";
        chk(tag, ir_env, e, $sformatf("slot %0d tick %0d", k, j));
        if (mode == 1 && k == 9 && j == 3) begin
          addr = ~a; cmd = ~c; send_req = 1'b1;
          @(negedge clk);
          send_req = 1'b0;
          chk("R8", busy, 1'b1, "late request keeps frame");
          chk("R8", ir_env, e, "late request keeps env");
        end
        if (mode == 2 && k == 12 && j == 5) begin
          repeat (25) begin
            @(negedge clk);
            chk("R3", ir_env, e, "no tick hold");
          end
          chk("R3", busy, 1'b1, "busy held without tick");
        end
        if (k == 27 && j == int'(HALF) - 1)
          chk("R2", busy, 1'b1, "busy before final tick");
        tick_once();
      end
    end
    chk("R9", busy, 1'b0, "busy after frame");
    chk("R9", ir_env, 1'b0, "env after frame");
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_frame(5'h15, 7'h3A, 0);
    t_frame(5'h00, 7'h7F, 0);
    t_frame(5'h1F, 7'h00, 1);
    t_frame(5'h0A, 7'h55, 2);
    t_frame(5'h11, 7'h2C, 0);
    summary();
    $finish;
  end
endmodule